// File: doc/BRIEF.md
# Exception Entry Arbiter

This block decides, at each instruction boundary of a small 32-bit processor, whether execution must be diverted into an exception handler and, if so, which one. It watches two active-low interrupt pins through a synchroniser. It also watches five request sources from the pipeline: a data abort, a prefetch-abort tag carried by the instruction at the head of the pipeline, an undefined-instruction request, a software-interrupt request and reset. When a boundary arrives, a fixed priority picks one winner.

The winner is announced one cycle later with a single-cycle `take` strobe. Alongside the strobe the block gives the handler vector, the new 5-bit processor mode, the new values of the two interrupt-mask bits, a strobe that tells the register file to save the status word, and the return-link value. The link is derived from the reference address that the pipeline supplies with the boundary. Requests that lose stay asserted by their sources and compete again at the next boundary.

A small state machine sequences the block through three states. `ST_BOOT` is held during reset. `ST_IDLE` waits for a boundary. `ST_ENTRY` is the one cycle in which the strobe is high. The transitions are: BOOT→ENTRY on the first clock after reset is released (the reset entry), IDLE→ENTRY on a boundary with a winner, IDLE→IDLE on a boundary with no winner or when there is no boundary, and ENTRY→IDLE always.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low, `take` is 0 at once, without waiting for a clock edge. On the first rising edge after release the block enters `ST_ENTRY` with reset information: `vector`=0x00, `new_mode`=10011, `new_f`=1, `new_i`=1, `save_psr`=0, `link`=0.
- R2: The fixed priority, from highest to lowest, is: data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt. The last two are never requested together.
- R3: The vectors are 0x04 for undefined instruction, 0x08 for software interrupt, 0x0C for prefetch abort, 0x10 for data abort, 0x18 for the normal interrupt and 0x1C for the fast interrupt. 0x14 is never produced.
- R4: `new_mode` is 10001 for the fast interrupt, 10010 for the normal interrupt, 10111 for either abort, 10011 for software interrupt and 11011 for undefined instruction.
- R5: A fast-interrupt entry sets `new_f` and `new_i` to 1. Every other non-reset entry sets `new_i` to 1 and passes `cur_f` (sampled at the boundary) through to `new_f`.
- R6: `link` equals `exec_addr` (sampled at the boundary) plus 8 for a data abort and plus 4 for every other non-reset exception.
- R7: Each interrupt pin passes through one synchroniser register. A pin that first goes low in the boundary cycle itself is not seen at that boundary.
- R8: The fast interrupt is ignored while `cur_f`=1, and the normal interrupt is ignored while `cur_i`=1.
- R9: Requests are evaluated only in a cycle where `insn_done`=1. Requests present without a boundary produce no `take`.
- R10: A prefetch abort is taken only when `head_pabt`=1 and `head_exec`=1 at the boundary. If the tagged instruction is flushed (`head_exec`=0), nothing is taken.
- R11: `take` is high for exactly one cycle: the cycle after the boundary edge. `save_psr` equals `take` for every entry except the reset entry. A boundary during the `take` cycle is not evaluated.
- R12: A boundary with no active request produces no `take`, and all entry outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, also the reset exception |
| fiq_n | input | 1 | Fast interrupt pin, active low, asynchronous |
| irq_n | input | 1 | Normal interrupt pin, active low, asynchronous |
| insn_done | input | 1 | Instruction-boundary strobe |
| exec_addr | input | ADDR_W | Reference address used to form the link |
| dabt_req | input | 1 | Data abort request |
| head_pabt | input | 1 | Prefetch-abort tag on the head instruction |
| head_exec | input | 1 | Head instruction really executes (not flushed) |
| und_req | input | 1 | Undefined instruction request |
| swi_req | input | 1 | Software interrupt request |
| cur_f | input | 1 | Current fast-interrupt mask bit |
| cur_i | input | 1 | Current normal-interrupt mask bit |
| take | output | 1 | Single-cycle exception entry strobe |
| vector | output | ADDR_W | Handler vector address |
| new_mode | output | 5 | Mode field on entry |
| new_f | output | 1 | Fast-interrupt mask on entry |
| new_i | output | 1 | Normal-interrupt mask on entry |
| save_psr | output | 1 | Strobe to save the status word |
| link | output | ADDR_W | Return-link value |

## Verification
Several rules are checked on every cycle. These are: the strobe is one cycle wide, 0x14 is never produced, each vector pairs with its mode and its mask bits, the data-abort link offset holds, and no entry comes without a boundary or while the fast interrupt is masked. Other behaviour can only be shown by the bench's scenarios. That covers the full priority order, the synchroniser delay (a pin that falls too late is missed), the prefetch-abort flush and the exact reset-entry values. The bench checks these against its own reference model under random and directed stimulus.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [2:0] {
        EK_NONE  = 3'd0,
        EK_RESET = 3'd1,
        EK_UND   = 3'd2,
        EK_SWI   = 3'd3,
        EK_PABT  = 3'd4,
        EK_DABT  = 3'd5,
        EK_IRQ   = 3'd6,
        EK_FIQ   = 3'd7
    } exc_kind_e;

    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_ENTRY = 2'd2
    } exc_state_e;

    localparam logic [4:0] MODE_FAST  = 5'b10001;
    localparam logic [4:0] MODE_NORM  = 5'b10010;
    localparam logic [4:0] MODE_SUPV  = 5'b10011;
    localparam logic [4:0] MODE_ABRT  = 5'b10111;
    localparam logic [4:0] MODE_UNDEF = 5'b11011;

    function automatic logic [7:0] vec_offset(input exc_kind_e k);
        unique case (k)
            EK_UND:  return 8'h04;
            EK_SWI:  return 8'h08;
            EK_PABT: return 8'h0C;
            EK_DABT: return 8'h10;
            EK_IRQ:  return 8'h18;
            EK_FIQ:  return 8'h1C;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [4:0] mode_of(input exc_kind_e k);
        unique case (k)
            EK_FIQ:          return MODE_FAST;
            EK_IRQ:          return MODE_NORM;
            EK_PABT, EK_DABT: return MODE_ABRT;
            EK_UND:          return MODE_UNDEF;
            default:         return MODE_SUPV;
        endcase
    endfunction

    function automatic logic [3:0] link_offset(input exc_kind_e k);
        return (k == EK_DABT) ? 4'd8 : 4'd4;
    endfunction

endpackage

// File: rtl/exc_sync.sv
module exc_sync #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= pin_n;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic      fiq_sync_n,
    input  logic      irq_sync_n,
    input  logic      cur_f,
    input  logic      cur_i,
    input  logic      dabt_req,
    input  logic      head_pabt,
    input  logic      head_exec,
    input  logic      und_req,
    input  logic      swi_req,
    output exc_kind_e winner
);
    logic fiq_live, irq_live, pabt_live;

    always_comb begin
        fiq_live  = !fiq_sync_n && !cur_f;
        irq_live  = !irq_sync_n && !cur_i;
        pabt_live = head_pabt && head_exec;
        if (dabt_req)       winner = EK_DABT;
        else if (fiq_live)  winner = EK_FIQ;
        else if (irq_live)  winner = EK_IRQ;
        else if (pabt_live) winner = EK_PABT;
        else if (und_req)   winner = EK_UND;
        else if (swi_req)   winner = EK_SWI;
        else                winner = EK_NONE;
    end
endmodule

// File: rtl/exc_fsm.sv
module exc_fsm
    import exc_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter logic [31:0] VEC_BASE = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_done,
    input  exc_kind_e         winner,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic              cur_f,
    output logic              take,
    output logic [ADDR_W-1:0] vector,
    output logic [4:0]        new_mode,
    output logic              new_f,
    output logic              new_i,
    output logic              save_psr,
    output logic [ADDR_W-1:0] link
);
    exc_state_e        state, state_nx;
    exc_kind_e         rec_kind;
    logic [ADDR_W-1:0] rec_link;
    logic              rec_f;
    logic              go;

    assign go = (state == ST_IDLE) && insn_done && (winner != EK_NONE);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_BOOT:  state_nx = ST_ENTRY;
            ST_IDLE:  state_nx = go ? ST_ENTRY : ST_IDLE;
            ST_ENTRY: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_BOOT;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_kind <= EK_RESET;
            rec_link <= '0;
            rec_f    <= 1'b1;
        end else if (state == ST_BOOT) begin
            rec_kind <= EK_RESET;
            rec_link <= '0;
            rec_f    <= 1'b1;
        end else if (go) begin
            rec_kind <= winner;
            rec_link <= exec_addr + ADDR_W'(link_offset(winner));
            rec_f    <= cur_f;
        end
    end

    always_comb begin
        take     = 1'b0;
        vector   = '0;
        new_mode = '0;
        new_f    = 1'b0;
        new_i    = 1'b0;
        save_psr = 1'b0;
        link     = '0;
        unique case (state)
            ST_ENTRY: begin
                take     = 1'b1;
                vector   = ADDR_W'(VEC_BASE) + ADDR_W'(vec_offset(rec_kind));
                new_mode = mode_of(rec_kind);
                new_i    = 1'b1;
                new_f    = (rec_kind == EK_FIQ || rec_kind == EK_RESET) ? 1'b1 : rec_f;
                save_psr = (rec_kind != EK_RESET);
                link     = rec_link;
            end
            ST_BOOT, ST_IDLE: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter int          SYNC_STAGES = 1,
    parameter logic [31:0] VEC_BASE    = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fiq_n,
    input  logic              irq_n,
    input  logic              insn_done,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic              dabt_req,
    input  logic              head_pabt,
    input  logic              head_exec,
    input  logic              und_req,
    input  logic              swi_req,
    input  logic              cur_f,
    input  logic              cur_i,
    output logic              take,
    output logic [ADDR_W-1:0] vector,
    output logic [4:0]        new_mode,
    output logic              new_f,
    output logic              new_i,
    output logic              save_psr,
    output logic [ADDR_W-1:0] link
);
    logic      fiq_s_n, irq_s_n;
    exc_kind_e winner;

    exc_sync #(.STAGES(SYNC_STAGES)) u_sync_fiq (
        .clk(clk), .rst_n(rst_n), .pin_n(fiq_n), .sync_n(fiq_s_n));
    exc_sync #(.STAGES(SYNC_STAGES)) u_sync_irq (
        .clk(clk), .rst_n(rst_n), .pin_n(irq_n), .sync_n(irq_s_n));

    exc_arbiter u_arb (
        .fiq_sync_n(fiq_s_n), .irq_sync_n(irq_s_n),
        .cur_f(cur_f), .cur_i(cur_i),
        .dabt_req(dabt_req), .head_pabt(head_pabt), .head_exec(head_exec),
        .und_req(und_req), .swi_req(swi_req), .winner(winner));

    exc_fsm #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .winner(winner),
        .exec_addr(exec_addr), .cur_f(cur_f),
        .take(take), .vector(vector), .new_mode(new_mode),
        .new_f(new_f), .new_i(new_i), .save_psr(save_psr), .link(link));
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int          ADDR_W   = 32,
    parameter logic [31:0] VEC_BASE = 32'h0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              insn_done,
    input logic [ADDR_W-1:0] exec_addr,
    input logic              cur_f,
    input logic              take,
    input logic [ADDR_W-1:0] vector,
    input logic [4:0]        new_mode,
    input logic              new_f,
    input logic              new_i,
    input logic              save_psr,
    input logic [ADDR_W-1:0] link
);
    localparam logic [ADDR_W-1:0] V_DABT = ADDR_W'(VEC_BASE) + ADDR_W'(8'h10);
    localparam logic [ADDR_W-1:0] V_FIQ  = ADDR_W'(VEC_BASE) + ADDR_W'(8'h1C);
    localparam logic [ADDR_W-1:0] V_RSVD = ADDR_W'(VEC_BASE) + ADDR_W'(8'h14);

    p_one_cycle_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);

    p_no_reserved_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> vector != V_RSVD);

    p_fiq_mode_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && vector == V_FIQ) |-> new_mode == 5'b10001);

    p_fiq_masks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && new_mode == 5'b10001) |-> (new_f && new_i));

    p_i_set_on_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> new_i);

    p_dabt_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && vector == V_DABT) |-> link == $past(exec_addr) + ADDR_W'(8));

    p_fiq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && new_mode == 5'b10001) |-> !$past(cur_f));

    p_boundary_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && save_psr) |-> $past(insn_done));

    p_quiet_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !take |-> (!save_psr && vector == '0 && link == '0));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_chk (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .exec_addr(exec_addr),
    .cur_f(cur_f), .take(take), .vector(vector), .new_mode(new_mode),
    .new_f(new_f), .new_i(new_i), .save_psr(save_psr), .link(link));

// File: tb/sim_exc_entry_ctrl.sv
`timescale 1ns/1ps
module sim_exc_entry_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fiq_n = 1'b1, irq_n = 1'b1, insn_done = 1'b0;
    logic [31:0] exec_addr = '0;
    logic        dabt_req = 0, head_pabt = 0, head_exec = 0, und_req = 0, swi_req = 0;
    logic        cur_f = 0, cur_i = 0;
    logic        take, new_f, new_i, save_psr;
    logic [31:0] vector, link;
    logic [4:0]  new_mode;

    int total = 0, bad = 0, cycles = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    exc_entry_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .fiq_n(fiq_n), .irq_n(irq_n),
        .insn_done(insn_done), .exec_addr(exec_addr), .dabt_req(dabt_req),
        .head_pabt(head_pabt), .head_exec(head_exec), .und_req(und_req),
        .swi_req(swi_req), .cur_f(cur_f), .cur_i(cur_i), .take(take),
        .vector(vector), .new_mode(new_mode), .new_f(new_f), .new_i(new_i),
        .save_psr(save_psr), .link(link));

    typedef struct packed {
        logic        tk;
        logic [31:0] vec;
        logic [4:0]  mode;
        logic        f, i, sv;
        logic [31:0] lnk;
    } exp_t;

    function automatic exp_t model(input logic da, fq, iq, pa, px, un, sw,
                                   input logic mf, mi, input logic [31:0] a);
        exp_t e = '0;
        e.tk = 1; e.i = 1; e.sv = 1; e.f = mf; e.lnk = a + 32'd4;
        if (da)              begin e.vec = 32'h10; e.mode = 5'b10111; e.lnk = a + 32'd8; end
        else if (fq && !mf)  begin e.vec = 32'h1C; e.mode = 5'b10001; e.f = 1; end
        else if (iq && !mi)  begin e.vec = 32'h18; e.mode = 5'b10010; end
        else if (pa && px)   begin e.vec = 32'h0C; e.mode = 5'b10111; end
        else if (un)         begin e.vec = 32'h04; e.mode = 5'b11011; end
        else if (sw)         begin e.vec = 32'h08; e.mode = 5'b10011; end
        else e = '0;
        return e;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_out(input string req, input exp_t e);
        check({req, " take"}, take, e.tk);
        check({req, " vector"}, vector, e.vec);
        check({req, " mode"}, new_mode, e.mode);
        check({req, " f"}, new_f, e.f);
        check({req, " i"}, new_i, e.i);
        check({req, " save"}, save_psr, e.sv);
        check({req, " link"}, link, e.lnk);
    endtask

    // pins set early (synchroniser), then one boundary; checks the take cycle and the one after
    task automatic boundary(input string req, input logic fq, iq, da, pa, px, un, sw,
                            input logic mf, mi, input logic [31:0] a);
        exp_t e;
        @(negedge clk);
        fiq_n = !fq; irq_n = !iq;
        @(negedge clk);
        dabt_req = da; head_pabt = pa; head_exec = px; und_req = un; swi_req = sw;
        cur_f = mf; cur_i = mi; exec_addr = a; insn_done = 1;
        @(negedge clk);
        insn_done = 0;
        e = model(da, fq, iq, pa, px, un, sw, mf, mi, a);
        check_out(req, e);
        dabt_req = 0; head_pabt = 0; head_exec = 0; und_req = 0; swi_req = 0;
        fiq_n = 1; irq_n = 1;
        @(negedge clk);
        check({req, " R11 strobe ends"}, take, 1'b0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        exp_t r;
        void'($urandom(32'd1234));
        // R1: reset state and reset entry
        #3;
        check("R1 take in reset", take, 1'b0);
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        r = '0; r.tk = 1; r.mode = 5'b10011; r.f = 1; r.i = 1;
        check_out("R1 reset entry", r);
        @(negedge clk);
        check("R1 back to idle", take, 1'b0);

        // R3/R4/R5/R6 each source alone
        boundary("R3 R4 undefined", 0,0,0,0,0,1,0, 0,0, 32'h100);
        boundary("R3 R4 swi", 0,0,0,0,0,0,1, 1,0, 32'h200);
        boundary("R10 R3 pabt executes", 0,0,0,1,1,0,0, 0,0, 32'h300);
        boundary("R6 R3 dabt link+8", 0,0,1,0,0,0,0, 0,0, 32'h400);
        boundary("R5 R3 fiq", 1,0,0,0,0,0,0, 0,0, 32'h500);
        boundary("R5 R3 irq keeps f", 0,1,0,0,0,0,0, 0,0, 32'h600);
        // R2 priority corners
        boundary("R2 dabt over fiq", 1,1,1,1,1,0,0, 0,0, 32'h700);
        boundary("R2 fiq over irq", 1,1,0,1,1,1,0, 0,0, 32'h800);
        boundary("R2 irq over pabt", 0,1,0,1,1,0,1, 0,0, 32'h900);
        boundary("R2 pabt over und", 0,0,0,1,1,1,0, 0,0, 32'hA00);
        // R8 masking
        boundary("R8 fiq masked irq wins", 1,1,0,0,0,0,0, 1,0, 32'hB00);
        boundary("R8 both masked", 1,1,0,0,0,0,0, 1,1, 32'hC00);
        // R10 flushed prefetch abort
        boundary("R10 pabt flushed", 0,0,0,1,0,0,0, 0,0, 32'hD00);
        // R12 nothing active
        boundary("R12 empty boundary", 0,0,0,0,0,0,0, 0,0, 32'hE00);

        // R7: pin falls in the boundary cycle only -> not seen
        @(negedge clk);
        fiq_n = 0; insn_done = 1; exec_addr = 32'h40;
        @(negedge clk);
        insn_done = 0;
        check("R7 late pin not seen", take, 1'b0);
        fiq_n = 1;
        @(negedge clk);

        // R9: requests without boundary
        @(negedge clk);
        dabt_req = 1; und_req = 1;
        @(negedge clk); @(negedge clk);
        check("R9 no boundary no take", take, 1'b0);
        // R11: boundary in take cycle ignored
        insn_done = 1;
        @(negedge clk);
        check("R11 take", take, 1'b1);
        @(negedge clk);
        check("R11 second boundary ignored", take, 1'b0);
        insn_done = 0; dabt_req = 0; und_req = 0;
        @(negedge clk);

        // R1: asynchronous reset mid-stream
        #1 rst_n = 0;
        #1 check("R1 async reset", take, 1'b0);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        check("R1 reset entry again", vector, 32'h0);
        check("R1 reset no save", save_psr, 1'b0);
        @(negedge clk);

        // random mix
        for (int n = 0; n < 300; n++) begin
            logic un, sw;
            un = $urandom_range(0, 3) == 0;
            sw = !un && ($urandom_range(0, 3) == 0);
            boundary("R2 R6 random",
                     1'($urandom_range(0,1)), 1'($urandom_range(0,1)),
                     $urandom_range(0,4) == 0, 1'($urandom_range(0,1)),
                     1'($urandom_range(0,1)), un, sw,
                     1'($urandom_range(0,1)), 1'($urandom_range(0,1)),
                     {$urandom_range(0, 32'h3FFF_FFFF), 2'b00});
        end

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule